// File: doc/BRIEF.md
# Masked burst address counter

This block generates the address sequence for one port of a synchronous memory. It holds three registers: an address counter, a mask that selects which low-order counter bits take part in counting, and a mirror that remembers the last start address written to the counter. On each clock edge a priority decoder turns the control strobes into exactly one operation. The operations are OP_CLEAR, OP_LOAD_CNT, OP_LOAD_MASK, OP_RETX, OP_STEP, OP_WRAP_ZERO, OP_WRAP_MIRROR and OP_IDLE. The datapath applies that operation to the registers.

When the unmasked field is already all ones, an increment becomes a wrap. Depending on the wrap input, the wrap either clears that field or reloads the whole counter from the mirror. Bits above the mask keep their loaded value while the counter steps. This lets a burst circle inside an aligned window of 2^k words.

A three-state phase machine drives the active-low interrupt. Its states are ST_IDLE, ST_RUN and ST_TERM:
- ST_IDLE is entered after master reset, OP_CLEAR, OP_LOAD_CNT or OP_RETX ("restart").
- An increment or wrap moves to ST_TERM when the resulting unmasked field is all ones ("hit top"), and to ST_RUN otherwise ("advance").
- OP_IDLE and OP_LOAD_MASK keep the current state ("hold").
- The interrupt is low only in ST_TERM.

Top module: `burst_addr_gen`

## Requirements
- R1: An active-low master reset acts asynchronously. It sets the counter and mirror to zero and the mask to all ones, and drives the interrupt high (deasserted).
- R2: load=1 with mask_sel=0 writes addr_in into both the counter and the mirror. The new value appears on addr_out after that clock edge.
- R3: load=1 with mask_sel=1 writes addr_in into the mask. The counter and the interrupt are unchanged.
- R4: A mask written through the load must be a contiguous run of ones starting at bit 0. An all-zero mask is allowed and makes every increment a wrap.
- R5: With cnt_en=1 and no higher-priority control, when the unmasked field is not all ones, that field increments by one and the masked-off high bits keep their value.
- R6: An increment while the unmasked field is all ones, with wrap_sel=0, clears the unmasked bits and keeps the high bits.
- R7: An increment while the unmasked field is all ones, with wrap_sel=1, loads the whole counter from the mirror.
- R8: retx=1 copies the mirror into the counter on the next edge.
- R9: cnt_rst=1 clears the counter and sets the mask to all ones. The mirror is kept.
- R10: When several controls are active in one cycle, priority from highest is cnt_rst, then load, then retx, then increment.
- R11: cnt_int_n goes low after an increment or wrap whose result has the unmasked field all ones. It goes high after OP_CLEAR, OP_LOAD_CNT, OP_RETX, or any increment whose result is not all ones. It holds otherwise.
- R12: With no control asserted, the counter and the interrupt hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| addr_in | input | AW | Start address or mask value |
| load | input | 1 | Load strobe, target chosen by mask_sel |
| cnt_en | input | 1 | Increment enable |
| cnt_rst | input | 1 | Synchronous counter reset |
| retx | input | 1 | Retransmit: reload counter from mirror |
| wrap_sel | input | 1 | Wrap action: 0 clears field, 1 reloads mirror |
| mask_sel | input | 1 | Load target: 0 counter and mirror, 1 mask |
| addr_out | output | AW | Current counter value |
| cnt_int_n | output | 1 | Terminal-count interrupt, active low |

## Verification
The bench builds the block with AW=10 instead of the default 18. With that width, a fully unmasked counter can climb from a loaded value to all ones and wrap within a few hundred cycles, so the terminal-count interrupt and both wrap modes can be reached with every bit counting as well as with narrow masks. Random mask widths from zero to the full 10 bits also produce the empty-mask case, where every increment wraps. Priority collisions between all four controls appear often enough in the random traffic to be covered beside the directed cases.

// File: rtl/mbc_pkg.sv
`timescale 1ns/1ps
package mbc_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CLEAR,
        OP_LOAD_CNT,
        OP_LOAD_MASK,
        OP_RETX,
        OP_STEP,
        OP_WRAP_ZERO,
        OP_WRAP_MIRROR
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_TERM
    } phase_e;
endpackage

// File: rtl/mbc_decode.sv
`timescale 1ns/1ps
module mbc_decode
    import mbc_pkg::*;
(
    input  logic cnt_rst,
    input  logic load,
    input  logic mask_sel,
    input  logic retx,
    input  logic cnt_en,
    input  logic wrap_sel,
    input  logic at_top,
    output op_e  op
);
    // Fixed priority: clear, load, retransmit, increment (R10)
    always_comb begin
        if (cnt_rst) begin
            op = OP_CLEAR;
        end else if (load) begin
            op = mask_sel ? OP_LOAD_MASK : OP_LOAD_CNT;
        end else if (retx) begin
            op = OP_RETX;
        end else if (cnt_en) begin
            if (!at_top) begin
                op = OP_STEP;
            end else begin
                op = wrap_sel ? OP_WRAP_MIRROR : OP_WRAP_ZERO;
            end
        end else begin
            op = OP_IDLE;
        end
    end
endmodule

// File: rtl/mbc_datapath.sv
`timescale 1ns/1ps
module mbc_datapath
    import mbc_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cnt_q,
    output logic          at_top,
    output logic          nxt_full
);
    localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};
    localparam logic [AW-1:0] ZERO     = {AW{1'b0}};
    localparam logic [AW-1:0] ONE      = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] mask_q;
    logic [AW-1:0] mirror_q;
    logic [AW-1:0] inc_raw;
    logic [AW-1:0] step_val;
    logic [AW-1:0] nxt_cnt;

    assign inc_raw = cnt_q + ONE;

    // Per-bit merge: masked bits take the incremented value, others hold
    for (genvar i = 0; i < AW; i++) begin : g_merge
        assign step_val[i] = mask_q[i] ? inc_raw[i] : cnt_q[i];
    end

    assign at_top = ((cnt_q & mask_q) == mask_q);

    always_comb begin
        nxt_cnt = cnt_q;
        unique case (op)
            OP_CLEAR:       nxt_cnt = ZERO;
            OP_LOAD_CNT:    nxt_cnt = addr_in;
            OP_RETX:        nxt_cnt = mirror_q;
            OP_STEP:        nxt_cnt = step_val;
            OP_WRAP_ZERO:   nxt_cnt = cnt_q & ~mask_q;
            OP_WRAP_MIRROR: nxt_cnt = mirror_q;
            OP_LOAD_MASK,
            OP_IDLE:        nxt_cnt = cnt_q;
            default:        nxt_cnt = cnt_q;
        endcase
    end

    assign nxt_full = ((nxt_cnt & mask_q) == mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= ZERO;
            mirror_q <= ZERO;
            mask_q   <= ALL_ONES;
        end else begin
            cnt_q <= nxt_cnt;
            if (op == OP_LOAD_CNT) mirror_q <= addr_in;
            if (op == OP_LOAD_MASK) mask_q <= addr_in;
            else if (op == OP_CLEAR) mask_q <= ALL_ONES;
        end
    end

    AST_HIGH_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=> ((cnt_q & ~mask_q) == $past(cnt_q & ~mask_q))); // R5
    AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRAP_ZERO) |=> ((cnt_q & mask_q) == ZERO)); // R6
    AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRAP_MIRROR) |=> (cnt_q == $past(mirror_q))); // R7
    AST_RETX_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RETX) |=> (cnt_q == $past(mirror_q))); // R8
    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (cnt_q == ZERO && mask_q == ALL_ONES && $stable(mirror_q))); // R9
    AST_MASK_LOAD_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD_MASK) |=> $stable(cnt_q)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/mbc_fsm.sv
`timescale 1ns/1ps
module mbc_fsm
    import mbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    input  logic nxt_full,
    output logic cnt_int_n
);
    phase_e state_q;
    phase_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_CLEAR,
            OP_LOAD_CNT,
            OP_RETX:        state_d = ST_IDLE;
            OP_STEP,
            OP_WRAP_ZERO,
            OP_WRAP_MIRROR: state_d = nxt_full ? ST_TERM : ST_RUN;
            OP_LOAD_MASK,
            OP_IDLE:        state_d = state_q;
            default:        state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cnt_int_n = (state_q != ST_TERM);
    end

    AST_RESTART_CLEARS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR || op == OP_LOAD_CNT || op == OP_RETX) |=> cnt_int_n); // R11
    AST_HOLD_KEEPS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE || op == OP_LOAD_MASK) |=> $stable(cnt_int_n)); // R12
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
    import mbc_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          load,
    input  logic          cnt_en,
    input  logic          cnt_rst,
    input  logic          retx,
    input  logic          wrap_sel,
    input  logic          mask_sel,
    output logic [AW-1:0] addr_out,
    output logic          cnt_int_n
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    op_e  op;
    logic at_top;
    logic nxt_full;

    mbc_decode u_decode (
        .cnt_rst  (cnt_rst),
        .load     (load),
        .mask_sel (mask_sel),
        .retx     (retx),
        .cnt_en   (cnt_en),
        .wrap_sel (wrap_sel),
        .at_top   (at_top),
        .op       (op)
    );

    mbc_datapath #(.AW(AW)) u_datapath (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .addr_in  (addr_in),
        .cnt_q    (addr_out),
        .at_top   (at_top),
        .nxt_full (nxt_full)
    );

    mbc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .nxt_full  (nxt_full),
        .cnt_int_n (cnt_int_n)
    );

    AST_MASK_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cnt_rst && mask_sel) |-> ((addr_in & (addr_in + ONE)) == '0)); // R4
    AST_LOAD_CNT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cnt_rst && !mask_sel) |=> (addr_out == $past(addr_in))); // R2
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (addr_out == '0 && cnt_int_n)); // R10
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] addr_in = '0;
    logic         load = 1'b0, cnt_en = 1'b0, cnt_rst = 1'b0;
    logic         retx = 1'b0, wrap_sel = 1'b0, mask_sel = 1'b0;
    logic [W-1:0] addr_out;
    logic         cnt_int_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] m_cnt, m_mir, m_mask;
    bit           m_term;

    always #2 clk = ~clk;

    burst_addr_gen #(.AW(W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .load(load),
        .cnt_en(cnt_en), .cnt_rst(cnt_rst), .retx(retx), .wrap_sel(wrap_sel),
        .mask_sel(mask_sel), .addr_out(addr_out), .cnt_int_n(cnt_int_n)
    );

    function automatic logic [W-1:0] field_step(logic [W-1:0] c, logic [W-1:0] m);
        return (c & ~m) | (((c & m) + 1'b1) & m);
    endfunction

    function automatic bit field_full(logic [W-1:0] c, logic [W-1:0] m);
        return (c & m) == m;
    endfunction

    function automatic logic [W-1:0] low_mask(int k);
        logic [W-1:0] r = '0;
        for (int i = 0; i < k; i++) r[i] = 1'b1;
        return r;
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_mir = '0; m_mask = '1; m_term = 1'b0;
    endtask

    // Drive one cycle at a falling edge, update model at the rising edge, check at the next falling edge
    task automatic cyc(bit r, bit l, bit ms, bit rt, bit en, bit ws, logic [W-1:0] a);
        string tag;
        cnt_rst = r; load = l; mask_sel = ms; retx = rt; cnt_en = en; wrap_sel = ws; addr_in = a;
        @(posedge clk);
        if (r) begin
            tag = "R9"; m_cnt = '0; m_mask = '1; m_term = 1'b0;
            if (l || rt || en) tag = "R10";
        end else if (l && !ms) begin
            tag = "R2"; m_cnt = a; m_mir = a; m_term = 1'b0;
            if (rt || en) tag = "R10";
        end else if (l) begin
            tag = "R3"; m_mask = a;
        end else if (rt) begin
            tag = en ? "R10" : "R8"; m_cnt = m_mir; m_term = 1'b0;
        end else if (en) begin
            if (!field_full(m_cnt, m_mask)) begin
                tag = "R5"; m_cnt = field_step(m_cnt, m_mask);
            end else if (ws) begin
                tag = "R7"; m_cnt = m_mir;
            end else begin
                tag = "R6"; m_cnt = m_cnt & ~m_mask;
            end
            m_term = field_full(m_cnt, m_mask);
        end else begin
            tag = "R12";
        end
        @(negedge clk);
        check(tag, addr_out, m_cnt, "addr_out");
        check(m_term ? "R11" : tag, {{(W-1){1'b0}}, cnt_int_n}, {{(W-1){1'b0}}, !m_term}, "cnt_int_n");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        #9;
        check("R1", addr_out, '0, "addr_out in reset");
        check("R1", {{(W-1){1'b0}}, cnt_int_n}, {{(W-1){1'b0}}, 1'b1}, "cnt_int_n in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R3/R4: narrow two-bit window, R2 start address
        cyc(0, 1, 1, 0, 0, 0, 10'h003);
        cyc(0, 1, 0, 0, 0, 0, 10'h2A4);
        cyc(0, 0, 0, 0, 1, 0, '0);
        cyc(0, 0, 0, 0, 1, 0, '0);
        cyc(0, 0, 0, 0, 1, 0, '0);      // R11: reaches 0x2A7
        cyc(0, 0, 0, 0, 0, 0, '0);      // R12 hold while terminal
        cyc(0, 1, 1, 0, 0, 0, 10'h003); // R3 mask reload keeps interrupt
        cyc(0, 0, 0, 0, 1, 0, '0);      // R6 wrap to zero field
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 1, '0);
        cyc(0, 0, 0, 0, 1, 1, '0);      // R7 wrap from mirror
        cyc(0, 0, 0, 0, 1, 0, '0);
        cyc(0, 0, 0, 1, 0, 0, '0);      // R8 retransmit
        // R10 priority collisions
        cyc(1, 1, 0, 1, 1, 1, 10'h155);
        cyc(0, 1, 0, 1, 1, 0, 10'h1F0);
        cyc(0, 0, 0, 0, 1, 0, '0);
        cyc(0, 0, 0, 1, 1, 0, '0);
        cyc(1, 0, 0, 0, 0, 0, '0);      // R9 mirror kept
        cyc(0, 0, 0, 1, 0, 0, '0);
        // full-width wrap with all bits counting
        cyc(0, 1, 0, 0, 0, 0, 10'h3FD);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0, '0);
        // empty mask: every increment wraps
        cyc(0, 1, 1, 0, 0, 0, 10'h000);
        cyc(0, 0, 0, 0, 1, 0, '0);
        cyc(0, 0, 0, 0, 1, 1, '0);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            bit r, l, ms, rt, en, ws;
            logic [W-1:0] a;
            r  = ($urandom_range(0, 63) == 0);
            l  = ($urandom_range(0, 15) == 0);
            ms = $urandom_range(0, 1) == 1;
            rt = ($urandom_range(0, 15) == 0);
            en = ($urandom_range(0, 3) != 0);
            ws = $urandom_range(0, 1) == 1;
            a  = W'($urandom);
            if (l && ms) a = low_mask($urandom_range(0, W));
            cyc(r, l, ms, rt, en, ws, a);
        end

        // R1: asynchronous master reset between edges
        cyc(0, 1, 0, 0, 0, 0, 10'h2C3);
        cnt_en = 1'b0; load = 1'b0;
        #1 rst_n = 1'b0;
        #0.5;
        model_reset();
        check("R1", addr_out, '0, "addr_out after async reset");
        check("R1", {{(W-1){1'b0}}, cnt_int_n}, {{(W-1){1'b0}}, 1'b1}, "cnt_int_n after async reset");
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 1, 0, 0, '0);      // R1 mirror cleared
        cyc(0, 0, 0, 0, 1, 0, '0);
        finish_run();
    end
endmodule